// File: doc/BRIEF.md
# Indexed Super-I/O Configuration Port

This block is a two-byte index/data configuration window in front of a 256-entry byte register file. It sits on a byte-wide I/O bus at a fixed pair of addresses (0x3F0 and 0x3F1 by default). Software first writes a register number to the lower address and then reads or writes that register through the upper address. The register number is kept in entry 0 of the file itself. Data writes reach only a set of writable entries; every other entry is fixed.

A separate byte-wide write path from the host bridge configuration space holds the gate for the whole window. Bit 1 of the byte written to bridge offset 0x85 opens or closes the window on every write to that offset. The window is closed after reset. While it is closed, the block answers no read and accepts no write, and the register file keeps its contents. Reset loads the identification and base-address defaults into the file.

Top module: `sio_cfg_port`

## Requirements
- R1: The port decodes only I/O addresses BASE_ADDR (index offset, 0x3F0) and BASE_ADDR+1 (data offset, 0x3F1). Reads at any other address give io_rack=0 and io_rdata=0, and writes there change nothing.
- R2: A write at the index offset stores io_wdata as the index in entry 0. A read at the index offset returns the current index.
- R3: A read at the data offset returns the entry that the index selects. When the index is 0x00, the read returns 0x00.
- R4: A write at the data offset updates the selected entry only when the index is one of 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 or 0xFC. A data write to any other index, 0x00 included, is ignored.
- R5: After reset the index is 0x00, entries 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE, and every other entry is 0x00.
- R6: Each bridge write (cfg_wr=1) to cfg_addr 0x85 sets the port enable to bit 1 of cfg_wdata. Bridge writes to other offsets leave the enable unchanged. The enable is 0 after reset.
- R7: While the enable is 0, io_rack and io_rdata stay 0 and all port writes are ignored. The index and all entries are kept across disable and re-enable.
- R8: io_rack and io_rdata answer a read in the same cycle. A write takes effect at the next rising clock edge, so a read and a write in the same cycle return the old value. io_rdata is 0 whenever io_rack is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O bus address |
| io_rd | input | 1 | I/O read strobe (single byte) |
| io_wr | input | 1 | I/O write strobe (single byte) |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, 0 when not acknowledged |
| io_rack | output | 1 | Read acknowledged by this port |
| cfg_wr | input | 1 | Host bridge configuration byte write strobe |
| cfg_addr | input | 8 | Host bridge configuration byte offset |
| cfg_wdata | input | 8 | Host bridge configuration write data |

## Verification
The bound checker tests these rules on every cycle: read data is zero whenever no acknowledge is given, an acknowledge appears only for a read at the two decoded addresses, an index write lands in the next cycle and the index is otherwise stable, an index read returns the stored index, data reads at index zero and at a sample read-only index return zero, and the enable follows each write to bridge offset 0x85. The full protection map, the reset defaults across all 256 entries, and the retention of contents through disable and re-enable show only in the bench. The bench drives its scenarios against a behavioural reference memory and compares the outputs on every clock.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

   typedef enum logic [1:0] {
      ENT_INDEX = 2'd0,
      ENT_RW    = 2'd1,
      ENT_RO    = 2'd2
   } entry_kind_e;

   // data-offset writes are accepted only for these entries
   function automatic logic entry_writable(input int unsigned i);
      case (i)
         8'hE0, 8'hE1, 8'hE2, 8'hE3,
         8'hE6, 8'hE7, 8'hE8,
         8'hEE, 8'hEF, 8'hF0, 8'hF1, 8'hF2,
         8'hF4, 8'hF6, 8'hF8, 8'hFC: entry_writable = 1'b1;
         default:                    entry_writable = 1'b0;
      endcase
   endfunction

   function automatic entry_kind_e entry_kind(input int unsigned i);
      if (i == 0)                entry_kind = ENT_INDEX;
      else if (entry_writable(i)) entry_kind = ENT_RW;
      else                       entry_kind = ENT_RO;
   endfunction

   function automatic logic [7:0] entry_reset(input int unsigned i);
      case (i)
         8'hE0:   entry_reset = 8'h3C;
         8'hE2:   entry_reset = 8'h03;
         8'hE3:   entry_reset = 8'hFC;
         8'hE6:   entry_reset = 8'hDE;
         8'hE7:   entry_reset = 8'hFE;
         8'hE8:   entry_reset = 8'hBE;
         default: entry_reset = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/sio_cfg_gate.sv
module sio_cfg_gate #(
   parameter int          CFG_AW    = 8,
   parameter int          CFG_DW    = 8,
   parameter logic [7:0]  GATE_OFFS = 8'h85,
   parameter int          GATE_BIT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   output logic              port_en
);

   generate
      if (GATE_BIT >= CFG_DW) begin : g_bad_bit
         $error("GATE_BIT outside cfg_wdata");
      end
   endgenerate

   logic hit_gate;
   assign hit_gate = cfg_wr && (cfg_addr == CFG_AW'(GATE_OFFS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        port_en <= 1'b0;
      else if (hit_gate) port_en <= cfg_wdata[GATE_BIT];
   end

endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode #(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              port_en,
   output logic              acc_hit,
   output logic              sel_data
);

   generate
      if (BASE_ADDR[0] != 1'b0) begin : g_bad_base
         $error("BASE_ADDR must be even");
      end
   endgenerate

   assign acc_hit  = port_en && (io_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
   assign sel_data = io_addr[0];

endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
   import sio_cfg_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_we,
   input  logic              dat_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] idx_q,
   output logic [DATA_W-1:0] dat_rd
);

   localparam int IDX_W   = DATA_W;
   localparam int ENTRIES = 1 << IDX_W;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("protection map is defined for byte indices only");
      end
   endgenerate

   logic [ENTRIES-1:0][DATA_W-1:0] ent;

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
         localparam entry_kind_e      KIND = entry_kind(g);
         localparam logic [DATA_W-1:0] RV  = DATA_W'(entry_reset(g));
         if (KIND == ENT_INDEX) begin : g_index
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      q <= RV;
               else if (idx_we) q <= wdata;
            end
            assign ent[g] = q;
         end else if (KIND == ENT_RW) begin : g_rw
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                                q <= RV;
               else if (dat_we && idx_q == IDX_W'(g))     q <= wdata;
            end
            assign ent[g] = q;
         end else begin : g_ro
            assign ent[g] = RV;
         end
      end
   endgenerate

   assign idx_q  = ent[0];
   assign dat_rd = (idx_q == '0) ? '0 : ent[idx_q];

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
   parameter int                DATA_W    = 8,
   parameter int                CFG_AW    = 8,
   parameter logic [7:0]        GATE_OFFS = 8'h85,
   parameter int                GATE_BIT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              io_rack,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata
);

   logic              port_en;
   logic              acc_hit;
   logic              sel_data;
   logic [DATA_W-1:0] idx_q;
   logic [DATA_W-1:0] dat_rd;

   sio_cfg_gate #(
      .CFG_AW(CFG_AW), .CFG_DW(8), .GATE_OFFS(GATE_OFFS), .GATE_BIT(GATE_BIT)
   ) gate_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .port_en(port_en)
   );

   sio_cfg_decode #(
      .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
   ) dec_i (
      .io_addr(io_addr), .port_en(port_en), .acc_hit(acc_hit), .sel_data(sel_data)
   );

   sio_cfg_regfile #(
      .DATA_W(DATA_W)
   ) rf_i (
      .clk(clk), .rst_n(rst_n),
      .idx_we(acc_hit && io_wr && !sel_data),
      .dat_we(acc_hit && io_wr &&  sel_data),
      .wdata(io_wdata), .idx_q(idx_q), .dat_rd(dat_rd)
   );

   assign io_rack  = acc_hit && io_rd;
   assign io_rdata = !io_rack ? '0 : (sel_data ? dat_rd : idx_q);

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
   parameter int                DATA_W    = 8,
   parameter int                CFG_AW    = 8,
   parameter logic [7:0]        GATE_OFFS = 8'h85,
   parameter int                GATE_BIT  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_rd,
   input logic              io_wr,
   input logic [DATA_W-1:0] io_wdata,
   input logic [DATA_W-1:0] io_rdata,
   input logic              io_rack,
   input logic              cfg_wr,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [7:0]        cfg_wdata,
   input logic              port_en,
   input logic              acc_hit,
   input logic [DATA_W-1:0] idx_q
);

   // R8
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rack |-> io_rdata == '0);

   // R1
   rack_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_rack |-> (io_rd && io_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]));

   // R7
   rack_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |-> !io_rack);

   // R2
   idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit && io_wr && !io_addr[0]) |=> idx_q == $past(io_wdata));

   // R2
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_hit && io_wr && !io_addr[0]) |=> $stable(idx_q));

   // R2
   idx_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rack && !io_addr[0]) |-> io_rdata == idx_q);

   // R3
   idx0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rack && io_addr[0] && idx_q == '0) |-> io_rdata == '0);

   // R4
   ro_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rack && io_addr[0] && idx_q == DATA_W'(8'hE4)) |-> io_rdata == '0);

   // R6
   gate_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == CFG_AW'(GATE_OFFS)) |=> port_en == $past(cfg_wdata[GATE_BIT]));

   // R6
   gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && cfg_addr == CFG_AW'(GATE_OFFS)) |=> $stable(port_en));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
   .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .DATA_W(DATA_W),
   .CFG_AW(CFG_AW), .GATE_OFFS(GATE_OFFS), .GATE_BIT(GATE_BIT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
   .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rack(io_rack),
   .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
   .port_en(port_en), .acc_hit(acc_hit), .idx_q(idx_q)
);

// File: tb/sio_cfg_port_tb_top.sv
module sio_cfg_port_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_rd = 1'b0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        io_rack;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference model
   int m_mem[256];
   int m_en;

   always #5 clk = ~clk;

   sio_cfg_port dut_i (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rack(io_rack),
      .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
   );

   function automatic bit m_writable(int i);
      return i inside {'hE0, 'hE1, 'hE2, 'hE3, 'hE6, 'hE7, 'hE8, 'hEE, 'hEF,
                       'hF0, 'hF1, 'hF2, 'hF4, 'hF6, 'hF8, 'hFC};
   endfunction

   function automatic void m_reset();
      for (int i = 0; i < 256; i++) m_mem[i] = 0;
      m_mem['hE0] = 'h3C; m_mem['hE2] = 'h03; m_mem['hE3] = 'hFC;
      m_mem['hE6] = 'hDE; m_mem['hE7] = 'hFE; m_mem['hE8] = 'hBE;
      m_en = 0;
   endfunction

   // one clock: inputs driven after negedge, compared before posedge, model updated at posedge
   task automatic cyc(string tag, logic [15:0] a, bit rd, bit wr, logic [7:0] wd,
                      bit cw = 0, logic [7:0] ca = 0, logic [7:0] cd = 0);
      int exp_ack, exp_dat;
      bit hit;
      io_addr = a; io_rd = rd; io_wr = wr; io_wdata = wd;
      cfg_wr = cw; cfg_addr = ca; cfg_wdata = cd;
      #2;
      hit = (m_en != 0) && (a[15:1] == 15'h01F8);
      exp_ack = (hit && rd) ? 1 : 0;
      exp_dat = 0;
      if (exp_ack != 0) exp_dat = a[0] ? ((m_mem[0] == 0) ? 0 : m_mem[m_mem[0]]) : m_mem[0];
      checks++;
      if (int'(io_rack) != exp_ack || int'(io_rdata) != exp_dat) begin
         failures++;
         $display("FAIL %s addr=%h idx=%0h: rack=%0d rdata=%h expected rack=%0d rdata=%h",
                  tag, a, m_mem[0], io_rack, io_rdata, exp_ack, exp_dat[7:0]);
      end
      @(posedge clk);
      if (hit && wr) begin
         if (!a[0]) m_mem[0] = wd;
         else if (m_writable(m_mem[0])) m_mem[m_mem[0]] = wd;
      end
      if (cw && ca == 8'h85) m_en = cd[1];
      @(negedge clk);
      io_rd = 0; io_wr = 0; cfg_wr = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      repeat (2) @(negedge clk);
      m_reset();
      rst_n = 1;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R7 / R6: closed after reset
      cyc("R6", 16'h03F0, 1, 0, 0);
      cyc("R7", 16'h03F1, 1, 1, 8'h55);
      // R6: open the window
      cyc("R6", 16'h0000, 0, 0, 0, 1, 8'h85, 8'h02);
      // R5 / R3 / R2: defaults of every entry
      for (int i = 0; i < 256; i++) begin
         cyc("R2", 16'h03F0, 1, 1, 8'(i));
         cyc("R5", 16'h03F1, 1, 0, 0);
      end
      // R4: attempt to write every entry, read back
      for (int i = 0; i < 256; i++) begin
         cyc("R2", 16'h03F0, 0, 1, 8'(i));
         cyc("R4", 16'h03F1, 0, 1, 8'(i ^ 'hA5));
         cyc("R4", 16'h03F1, 1, 0, 0);
      end
      // R3: index 0 reads as zero even after a data write attempt
      cyc("R3", 16'h03F0, 0, 1, 8'h00);
      cyc("R3", 16'h03F1, 1, 1, 8'h77);
      cyc("R3", 16'h03F1, 1, 0, 0);
      // R8: read and write together return the old value
      cyc("R8", 16'h03F0, 0, 1, 8'hF4);
      cyc("R8", 16'h03F1, 1, 1, 8'h12);
      cyc("R8", 16'h03F1, 1, 1, 8'h34);
      cyc("R8", 16'h03F1, 1, 0, 0);
      // R1: neighbouring and aliased addresses
      cyc("R1", 16'h03F2, 1, 1, 8'hE0);
      cyc("R1", 16'h02F0, 1, 1, 8'hE1);
      cyc("R1", 16'h13F1, 1, 1, 8'h99);
      cyc("R1", 16'h03F0, 1, 0, 0);
      cyc("R1", 16'h03F1, 1, 0, 0);
      // R6: other bridge offsets leave the enable alone
      cyc("R6", 16'h0000, 0, 0, 0, 1, 8'h84, 8'h00);
      cyc("R6", 16'h03F0, 1, 0, 0, 1, 8'h86, 8'h00);
      // R6 / R7: close with bit 1 clear, other bits set
      cyc("R6", 16'h0000, 0, 0, 0, 1, 8'h85, 8'hFD);
      cyc("R7", 16'h03F0, 1, 1, 8'hE7);
      cyc("R7", 16'h03F1, 1, 1, 8'h00);
      cyc("R7", 16'h03F0, 1, 0, 0);
      // R7: reopen, contents and index kept
      cyc("R7", 16'h0000, 0, 0, 0, 1, 8'h85, 8'h02);
      cyc("R7", 16'h03F0, 1, 0, 0);
      cyc("R7", 16'h03F1, 1, 0, 0);
      cyc("R7", 16'h03F0, 0, 1, 8'hE0);
      cyc("R7", 16'h03F1, 1, 0, 0);
      // R5: reset again restores defaults and closes the window
      do_reset();
      cyc("R5", 16'h03F0, 1, 0, 0);
      cyc("R5", 16'h0000, 0, 0, 0, 1, 8'h85, 8'h02);
      cyc("R5", 16'h03F0, 1, 0, 0);
      foreach (m_mem[i]) if (i >= 'hE0) begin
         cyc("R5", 16'h03F0, 0, 1, 8'(i));
         cyc("R5", 16'h03F1, 1, 0, 0);
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule